// File: doc/BRIEF.md
# Packed Sub-Word Adder/Subtractor

This block runs one 64-bit add or subtract over a word that holds several small integers side by side. A two-bit layout select splits the datapath into eight byte lanes, four 16-bit lanes or two 32-bit lanes. Every lane gets the same operation in the same cycle. The carry chain is cut at each lane edge, so the lanes cannot disturb one another.

Each lane reports unsigned overflow on its own flag. When clamping is enabled, a lane that overflows is pinned to its unsigned limit instead of wrapping. Operands are sampled when `in_valid` is high. The packed result and the flags appear on registered outputs one clock later, and they hold until the next valid operation.

Top module: `packed_lane_adder`

## Requirements
- R1: With `lane_mode`=2'b00, lane k (k=0..7) occupies bits [8k+7:8k], and with `sub`=0 and `sat_en`=0 its result is (a+b) mod 256.
- R2: With `lane_mode`=2'b01, lane k (k=0..3) occupies bits [16k+15:16k] and its result is computed modulo 2^16.
- R3: With `lane_mode`=2'b10 or 2'b11, lane k (k=0..1) occupies bits [32k+31:32k] and its result is computed modulo 2^32.
- R4: No carry or borrow passes from one lane into the next, including when every bit of a lane is at its limit.
- R5: With `sub`=1, each lane returns (a-b) mod 2^w, where w is the lane width.
- R6: Bit k of `ovf` is 1 when lane k overflows unsigned: a carry out of the lane on add, or a<b on subtract. Flag bits at or above the active lane count read 0.
- R7: With `sat_en`=1, an overflowing lane returns 2^w-1 on add and 0 on subtract, and its flag is still set. Lanes that do not overflow are not altered.
- R8: `out_valid`, `sum` and `ovf` update on the first rising clock edge after `in_valid` is sampled high. While `in_valid` is low, `out_valid` is 0 and `sum` and `ovf` keep their values.
- R9: While `rst_n` is low, `out_valid`, `sum` and `ovf` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 64 | First packed operand |
| op_b | input | 64 | Second packed operand |
| lane_mode | input | 2 | Lane layout: 00 = 8-bit, 01 = 16-bit, 1x = 32-bit |
| sub | input | 1 | 0 = add, 1 = subtract (a-b) |
| sat_en | input | 1 | Clamp overflowing lanes to their unsigned limit |
| out_valid | output | 1 | Result registers were loaded on the last edge |
| sum | output | 64 | Packed result |
| ovf | output | 8 | Per-lane unsigned overflow flags |

## Verification
Every result, flag and valid bit is due on the first rising edge after the operation is presented, and no later. The bench drives each operation on a falling edge and compares against its lane-by-lane integer model at the next falling edge, which lies half a period past the loading edge. Idle cycles with scrambled operand inputs are checked at that same point, to confirm that the outputs held and that `out_valid` dropped.

// File: rtl/packed_lane_adder.sv
module packed_lane_adder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] op_a,
  input  logic [63:0] op_b,
  input  logic [1:0]  lane_mode,
  input  logic        sub,
  input  logic        sat_en,
  output logic        out_valid,
  output logic [63:0] sum,
  output logic [7:0]  ovf
);
  localparam int NB = 8;
  localparam int BW = 8;

  logic [63:0]   b_eff, raw, res;
  logic [NB-1:0] cin, cout, lane_ov, flag;

  assign b_eff = sub ? ~op_b : op_b;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    localparam bit HALF_START = (i % 2 == 0);
    localparam bit QUAD_START = (i % 4 == 0);
    logic starts;
    logic top_c;
    assign starts = (lane_mode == 2'b00) ? 1'b1 :
                    (lane_mode == 2'b01) ? HALF_START : QUAD_START;
    if (i == 0) begin : g_first
      assign cin[i] = sub;
    end else begin : g_rest
      assign cin[i] = starts ? sub : cout[i-1];
    end
    assign {cout[i], raw[BW*i +: BW]} = {1'b0, op_a[BW*i +: BW]} + {1'b0, b_eff[BW*i +: BW]} + 9'(cin[i]);
    assign top_c = (lane_mode == 2'b00) ? cout[i] :
                   (lane_mode == 2'b01) ? cout[i | 1] : cout[i | 3];
    assign lane_ov[i] = sub ? ~top_c : top_c;
    assign res[BW*i +: BW] = (sat_en && lane_ov[i]) ? {BW{~sub}} : raw[BW*i +: BW];

    a_r7_sat_byte: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(sat_en) && $past(lane_mode) == 2'b00 && ovf[i]
        |-> sum[BW*i +: BW] == {BW{~$past(sub)}});

    if (i < 2) begin : g_f2
      assign flag[i] = (lane_mode == 2'b00) ? lane_ov[i] :
                       (lane_mode == 2'b01) ? lane_ov[2*i] : lane_ov[4*i];
    end else if (i < 4) begin : g_f4
      assign flag[i] = (lane_mode == 2'b00) ? lane_ov[i] :
                       (lane_mode == 2'b01) ? lane_ov[2*i] : 1'b0;
    end else begin : g_f8
      assign flag[i] = (lane_mode == 2'b00) ? lane_ov[i] : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sum       <= '0;
      ovf       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sum <= res;
        ovf <= flag;
      end
    end
  end

  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(sum) && $stable(ovf));

  a_r6_half_flags: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(lane_mode) != 2'b00 |-> ovf[7:4] == 4'b0);

  a_r6_quad_flags: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(lane_mode[1]) |-> ovf[7:2] == 6'b0);
endmodule

// File: tb/test_packed_lane_adder.sv
module test_packed_lane_adder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [1:0] lane_mode = 2'b00;
  logic sub = 1'b0, sat_en = 1'b0;
  logic out_valid;
  logic [63:0] sum;
  logic [7:0] ovf;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [63:0] last_s = '0;
  logic [7:0] last_f = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  packed_lane_adder i_packed_lane_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .lane_mode(lane_mode), .sub(sub), .sat_en(sat_en),
    .out_valid(out_valid), .sum(sum), .ovf(ovf));

  function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                input logic [1:0] m, input logic s, input logic sat,
                                output logic [63:0] es, output logic [7:0] ef);
    int w = (m == 2'b00) ? 8 : (m == 2'b01) ? 16 : 32;
    logic [64:0] mask = (65'd1 << w) - 65'd1;
    es = '0;
    ef = '0;
    for (int k = 0; k < 64 / w; k++) begin
      logic [64:0] ua = ({1'b0, a} >> (k * w)) & mask;
      logic [64:0] ub = ({1'b0, b} >> (k * w)) & mask;
      logic [64:0] r = s ? (ua - ub) : (ua + ub);
      logic ov = s ? (ua < ub) : (r > mask);
      r = r & mask;
      if (sat && ov) r = s ? 65'd0 : mask;
      es = es | (r[63:0] << (k * w));
      ef[k] = ov;
    end
  endfunction

  task automatic check(input string tag, input logic v, input logic [63:0] es, input logic [7:0] ef);
    checks++;
    if (out_valid !== v || sum !== es || ovf !== ef) begin
      fails++;
      $display("FAIL %s: got valid=%0b sum=%h ovf=%h, expected valid=%0b sum=%h ovf=%h",
               tag, out_valid, sum, ovf, v, es, ef);
    end
  endtask

  task automatic apply(input string tag, input logic [63:0] a, input logic [63:0] b,
                       input logic [1:0] m, input logic s, input logic sat);
    logic [63:0] es;
    logic [7:0] ef;
    op_a = a; op_b = b; lane_mode = m; sub = s; sat_en = sat; in_valid = 1'b1;
    model(a, b, m, s, sat, es, ef);
    @(negedge clk);
    check(tag, 1'b1, es, ef);
    last_s = es;
    last_f = ef;
  endtask

  task automatic idle();
    in_valid = 1'b0;
    op_a = {$urandom, $urandom}; op_b = {$urandom, $urandom};
    lane_mode = 2'($urandom); sub = 1'($urandom); sat_en = 1'($urandom);
    @(negedge clk);
    check("R8 hold while idle", 1'b0, last_s, last_f);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: got no finish, expected end of run");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset state", 1'b0, 64'd0, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", 1'b0, 64'd0, 8'd0);

    apply("R1 byte add", 64'h0102_0304_0506_0708, 64'h1010_1010_1010_1010, 2'b00, 0, 0);
    apply("R4 R6 byte carry blocked", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'b00, 0, 0);
    apply("R4 byte isolation", 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'b00, 0, 0);
    apply("R2 R6 half add", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 2'b01, 0, 0);
    apply("R2 half add no ovf", 64'h1234_00FF_7FFF_8000, 64'h1111_0001_0001_7FFF, 2'b01, 0, 0);
    apply("R3 R4 quad add", 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b10, 0, 0);
    apply("R3 quad mode 11", 64'hFFFF_FFFF_8000_0000, 64'h0000_0001_8000_0000, 2'b11, 0, 0);
    apply("R5 R6 byte sub borrow", 64'h0010_2030_4050_6070, 64'h0100_1040_3060_7080, 2'b00, 1, 0);
    apply("R5 R4 half sub", 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, 2'b01, 1, 0);
    apply("R5 quad sub equal", 64'hDEAD_BEEF_0000_0000, 64'hDEAD_BEEF_0000_0001, 2'b10, 1, 0);
    apply("R7 byte add clamp", 64'hF0F0_1010_FF00_8080, 64'h2020_1010_0101_8080, 2'b00, 0, 1);
    apply("R7 byte sub clamp", 64'h0010_2030_4050_6070, 64'h0100_1040_3060_7080, 2'b00, 1, 1);
    apply("R7 half add clamp", 64'hFFF0_0001_8000_0000, 64'h0020_0001_8000_0000, 2'b01, 0, 1);
    apply("R7 quad sub clamp", 64'h0000_0005_0000_0009, 64'h0000_0007_0000_0003, 2'b10, 1, 1);
    idle();
    idle();

    for (int n = 0; n < 400; n++) begin
      logic [1:0] m = 2'($urandom);
      logic s = 1'($urandom);
      logic sat = 1'($urandom);
      string tag = (m == 2'b00) ? "R1" : (m == 2'b01) ? "R2" : "R3";
      if (s) tag = {tag, " R5"};
      if (sat) tag = {tag, " R7"};
      tag = {tag, " R6 random"};
      apply(tag, {$urandom, $urandom}, {$urandom, $urandom}, m, s, sat);
      if (n % 7 == 0) idle();
    end

    finish_run();
  end
endmodule